// File: doc/BRIEF.md
# Set-Associative Translation Lookaside Buffer

This block caches virtual-to-physical page translations for a small paged memory system. Virtual addresses are 14 bits and physical addresses are 12 bits, and a page holds 64 bytes. Sixteen translations are held as four sets of four ways. A lookup returns its result in the same cycle, so an address unit can place the block directly in its translation path. On a miss the block only reports the miss. The table walk that runs afterwards lives elsewhere and sends the resulting translation back through the fill port.

A fill normally picks its way without help from the caller. It reuses the way that already holds the same tag if there is one. If not, it takes the lowest-numbered empty way. If the set is full, it takes the way named by that set's rotating victim pointer. A caller can also force a fill into a named way. A task-switch flush clears every translation except those marked global.

The fill way is chosen by a priority selector with four named sources, tried in this order:
- PICK_STEER: the way forced by the caller.
- PICK_RESIDENT: the way already holding the tag.
- PICK_FREE: the lowest empty way.
- PICK_ROTATE: the way given by the set's victim pointer.

Each set's victim pointer is a small state register with two transitions. It returns to way 0 on reset, and it steps to the next way (wrapping from 3 to 0) on every fill to its set.

Top module: `tlb_xlate`

## Requirements
- R1: Reset (active-low, synchronous) clears every entry, global ones included, so every lookup misses afterwards.
- R2: For lookups, the virtual page number is vaddr[13:6]. Its bits [1:0] select the set and bits [7:2] form the tag. A hit needs a valid entry in that set with an equal tag. Entries in other sets, or with other tags, never hit.
- R3: Lookup is combinational. On a hit, lk_ppn_o gives the stored physical page and lk_paddr_o gives {ppn, vaddr[5:0]}. On a miss, lk_hit_o, lk_ppn_o and lk_paddr_o are all zero.
- R4: A fill is written at the clock edge where fill_en_i is high, and a lookup of that page hits with the new ppn in the next cycle.
- R5: An unsteered fill of a new tag into a set with an empty way uses the lowest-numbered empty way, and evicts nothing.
- R6: An unsteered fill of a new tag into a full set replaces the way named by that set's victim pointer. The pointer advances by one (modulo 4) on every fill to its set, whichever way the fill uses.
- R7: An unsteered fill whose tag already sits in a valid way of the set overwrites that way in place. It never creates a second copy and never evicts another way.
- R8: A steered fill (fill_steer_i=1) writes way fill_way_i of the set. Any other way in that set holding the same tag is invalidated, so one tag never hits in two ways.
- R9: flush_i invalidates every entry whose global flag is clear and leaves entries with the flag set valid and unchanged.
- R10: If a fill and a flush happen in the same cycle, the filled entry is valid afterwards, even when it is not global.
- R11: Reset returns every set's victim pointer to way 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_vaddr_i | input | 14 | Virtual address to translate |
| lk_hit_o | output | 1 | Translation found |
| lk_ppn_o | output | 6 | Physical page number on hit, zero on miss |
| lk_paddr_o | output | 12 | Physical address on hit, zero on miss |
| fill_en_i | input | 1 | Write a translation this cycle |
| fill_vpn_i | input | 8 | Virtual page number to install |
| fill_ppn_i | input | 6 | Physical page number to install |
| fill_glob_i | input | 1 | Installed entry survives flushes |
| fill_steer_i | input | 1 | Force the fill into fill_way_i |
| fill_way_i | input | 2 | Way used by a steered fill |
| flush_i | input | 1 | Invalidate all non-global entries |

## Verification
The victim pointers cannot be seen at the ports. The bench therefore drives known numbers of fills into one set and then checks, by looking up each resident page, which way was evicted. The reset test uses the same method: it leaves a pointer at a nonzero value, resets, and shows that the next eviction starts again from way 0. A tag held in two ways of one set can only arise through a steered fill. The bench steers a resident tag into a different way and then shows two things: the lookup returns only the new translation, and the way that was vacated is reused as the lowest empty way.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    parameter int VA_W = 14;
    parameter int PO_W = 6;
    parameter int PA_W = 12;
    parameter int SETS = 4;
    parameter int WAYS = 4;

    localparam int VPN_W = VA_W - PO_W;
    localparam int PPN_W = PA_W - PO_W;
    localparam int SET_W = $clog2(SETS);
    localparam int TAG_W = VPN_W - SET_W;
    localparam int WAY_W = $clog2(WAYS);
    localparam int ENT_N = SETS * WAYS;

    typedef struct packed {
        logic             valid;
        logic             glob;
        logic [TAG_W-1:0] tag;
        logic [PPN_W-1:0] ppn;
    } tlb_ent_t;

    typedef struct packed {
        logic             en;
        logic             glob;
        logic [VPN_W-1:0] vpn;
        logic [PPN_W-1:0] ppn;
    } fill_req_t;

    typedef enum logic [1:0] {
        PICK_STEER,
        PICK_RESIDENT,
        PICK_FREE,
        PICK_ROTATE
    } pick_e;
endpackage

// File: rtl/tlb_match.sv
module tlb_match
    import tlb_pkg::*;
(
    input  tlb_ent_t         row_i [WAYS],
    input  logic [TAG_W-1:0] tag_i,
    output logic [WAYS-1:0]  match_o,
    output logic             hit_o,
    output logic [WAY_W-1:0] way_o
);
    genvar w;
    generate
        for (w = 0; w < WAYS; w++) begin : g_cmp
            assign match_o[w] = row_i[w].valid && (row_i[w].tag == tag_i);
        end
    endgenerate

    assign hit_o = |match_o;

    // lowest matching way wins
    always_comb begin
        way_o = '0;
        for (int k = WAYS - 1; k >= 0; k--) begin
            if (match_o[k]) way_o = WAY_W'(k);
        end
    end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim
    import tlb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fill_en_i,
    input  logic [SET_W-1:0] set_i,
    input  logic [WAYS-1:0]  valid_i,
    input  logic             res_hit_i,
    input  logic [WAY_W-1:0] res_way_i,
    input  logic             steer_i,
    input  logic [WAY_W-1:0] steer_way_i,
    output logic [WAY_W-1:0] way_o
);
    logic [WAY_W-1:0] rr_q [SETS];
    logic             free_any;
    logic [WAY_W-1:0] free_way;
    pick_e            pick;

    always_comb begin
        free_any = 1'b0;
        free_way = '0;
        for (int k = WAYS - 1; k >= 0; k--) begin
            if (!valid_i[k]) begin
                free_any = 1'b1;
                free_way = WAY_W'(k);
            end
        end
    end

    always_comb begin
        if (steer_i)        pick = PICK_STEER;
        else if (res_hit_i) pick = PICK_RESIDENT;
        else if (free_any)  pick = PICK_FREE;
        else                pick = PICK_ROTATE;
    end

    always_comb begin
        unique case (pick)
            PICK_STEER:    way_o = steer_way_i;
            PICK_RESIDENT: way_o = res_way_i;
            PICK_FREE:     way_o = free_way;
            PICK_ROTATE:   way_o = rr_q[set_i];
            default:       way_o = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) rr_q[s] <= '0;
        end else if (fill_en_i) begin
            rr_q[set_i] <= rr_q[set_i] + WAY_W'(1);
        end
    end
endmodule

// File: rtl/tlb_store.sv
module tlb_store
    import tlb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_i,
    input  fill_req_t        fill_i,
    input  logic [WAY_W-1:0] fill_way_i,
    input  logic [WAYS-1:0]  dup_i,
    output tlb_ent_t         ents_o [SETS][WAYS]
);
    tlb_ent_t         ent_q [SETS][WAYS];
    logic [SET_W-1:0] fset;
    logic [TAG_W-1:0] ftag;

    assign fset = fill_i.vpn[SET_W-1:0];
    assign ftag = fill_i.vpn[VPN_W-1:SET_W];

    // later assignments take precedence: flush, then duplicate clear, then fill
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    ent_q[s][w] <= '0;
        end else begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    if (flush_i && !ent_q[s][w].glob) ent_q[s][w].valid <= 1'b0;
            if (fill_i.en) begin
                for (int w = 0; w < WAYS; w++)
                    if (dup_i[w]) ent_q[fset][w].valid <= 1'b0;
                ent_q[fset][fill_way_i] <= '{valid: 1'b1, glob: fill_i.glob,
                                             tag: ftag, ppn: fill_i.ppn};
            end
        end
    end

    assign ents_o = ent_q;
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
    import tlb_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [tlb_pkg::VA_W-1:0]   lk_vaddr_i,
    output logic                       lk_hit_o,
    output logic [tlb_pkg::PPN_W-1:0]  lk_ppn_o,
    output logic [tlb_pkg::PA_W-1:0]   lk_paddr_o,
    input  logic                       fill_en_i,
    input  logic [tlb_pkg::VPN_W-1:0]  fill_vpn_i,
    input  logic [tlb_pkg::PPN_W-1:0]  fill_ppn_i,
    input  logic                       fill_glob_i,
    input  logic                       fill_steer_i,
    input  logic [tlb_pkg::WAY_W-1:0]  fill_way_i,
    input  logic                       flush_i
);
    tlb_ent_t         ents [SETS][WAYS];
    tlb_ent_t         lk_row [WAYS];
    tlb_ent_t         fl_row [WAYS];
    logic [SET_W-1:0] lk_set, fl_set;
    logic [TAG_W-1:0] lk_tag, fl_tag;
    logic [WAYS-1:0]  lk_match, fl_match, fl_valid;
    logic             lk_hit, fl_hit;
    logic [WAY_W-1:0] lk_way, fl_res_way, fl_way;
    logic [ENT_N-1:0] valid_flat, glob_flat;
    fill_req_t        fill_req;

    assign lk_set = lk_vaddr_i[PO_W +: SET_W];
    assign lk_tag = lk_vaddr_i[VA_W-1 -: TAG_W];
    assign fl_set = fill_vpn_i[SET_W-1:0];
    assign fl_tag = fill_vpn_i[VPN_W-1:SET_W];

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            lk_row[w]   = ents[lk_set][w];
            fl_row[w]   = ents[fl_set][w];
            fl_valid[w] = ents[fl_set][w].valid;
        end
    end

    tlb_match u_look (
        .row_i(lk_row), .tag_i(lk_tag),
        .match_o(lk_match), .hit_o(lk_hit), .way_o(lk_way)
    );

    tlb_match u_fmatch (
        .row_i(fl_row), .tag_i(fl_tag),
        .match_o(fl_match), .hit_o(fl_hit), .way_o(fl_res_way)
    );

    tlb_victim u_victim (
        .clk(clk), .rst_n(rst_n), .fill_en_i(fill_en_i), .set_i(fl_set),
        .valid_i(fl_valid), .res_hit_i(fl_hit), .res_way_i(fl_res_way),
        .steer_i(fill_steer_i), .steer_way_i(fill_way_i), .way_o(fl_way)
    );

    assign fill_req = '{en: fill_en_i, glob: fill_glob_i,
                        vpn: fill_vpn_i, ppn: fill_ppn_i};

    tlb_store u_store (
        .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .fill_i(fill_req),
        .fill_way_i(fl_way), .dup_i(fl_match), .ents_o(ents)
    );

    genvar s, w;
    generate
        for (s = 0; s < SETS; s++) begin : g_s
            for (w = 0; w < WAYS; w++) begin : g_w
                assign valid_flat[s*WAYS + w] = ents[s][w].valid;
                assign glob_flat[s*WAYS + w]  = ents[s][w].glob;
            end
        end
    endgenerate

    assign lk_hit_o   = lk_hit;
    assign lk_ppn_o   = lk_hit ? lk_row[lk_way].ppn : '0;
    assign lk_paddr_o = lk_hit ? {lk_row[lk_way].ppn, lk_vaddr_i[PO_W-1:0]} : '0;
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk
    import tlb_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [VA_W-1:0]  lk_vaddr_i,
    input logic             lk_hit_o,
    input logic [PPN_W-1:0] lk_ppn_o,
    input logic             fill_en_i,
    input logic [VPN_W-1:0] fill_vpn_i,
    input logic [PPN_W-1:0] fill_ppn_i,
    input logic             fill_steer_i,
    input logic [WAY_W-1:0] fill_way_i,
    input logic             flush_i,
    input logic [WAYS-1:0]  lk_match,
    input logic [ENT_N-1:0] valid_flat,
    input logic [ENT_N-1:0] glob_flat
);
    // R1
    reset_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (valid_flat == '0));

    // R4
    fill_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en_i |=> ((lk_vaddr_i[VA_W-1:PO_W] != $past(fill_vpn_i)) ||
                       (lk_hit_o && (lk_ppn_o == $past(fill_ppn_i)))));

    // R9
    flush_keep_global_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_i && !fill_en_i) |=> ((valid_flat & ~glob_flat) == '0));

    // R7 R8
    single_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match));

    // R8
    steer_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en_i && fill_steer_i) |=>
            valid_flat[$past({fill_vpn_i[SET_W-1:0], fill_way_i})]);
endmodule

bind tlb_xlate tlb_xlate_chk u_chk (
    .clk(clk), .rst_n(rst_n), .lk_vaddr_i(lk_vaddr_i), .lk_hit_o(lk_hit_o),
    .lk_ppn_o(lk_ppn_o), .fill_en_i(fill_en_i), .fill_vpn_i(fill_vpn_i),
    .fill_ppn_i(fill_ppn_i), .fill_steer_i(fill_steer_i), .fill_way_i(fill_way_i),
    .flush_i(flush_i), .lk_match(lk_match), .valid_flat(valid_flat),
    .glob_flat(glob_flat)
);

// File: tb/tlb_xlate_bench.sv
module tlb_xlate_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] lk_vaddr_i = '0;
    logic        lk_hit_o;
    logic [5:0]  lk_ppn_o;
    logic [11:0] lk_paddr_o;
    logic        fill_en_i = 1'b0;
    logic [7:0]  fill_vpn_i = '0;
    logic [5:0]  fill_ppn_i = '0;
    logic        fill_glob_i = 1'b0;
    logic        fill_steer_i = 1'b0;
    logic [1:0]  fill_way_i = '0;
    logic        flush_i = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    tlb_xlate u_tlb_xlate (.*);

    localparam logic [1:0] OP_LOOK = 2'd0, OP_FILL = 2'd1, OP_FLUSH = 2'd2, OP_BOTH = 2'd3;

    typedef struct packed {
        logic [1:0] op;
        logic [3:0] req;
        logic [7:0] vpn;
        logic [5:0] off;
        logic [5:0] ppn;
        logic       glob;
        logic       steer;
        logic [1:0] way;
        logic       ehit;
        logic [5:0] eppn;
    } vec_t;

    localparam int NV = 43;
    localparam vec_t TBL [NV] = '{
        '{OP_LOOK,  4'd1,  8'h0F, 6'h14, 6'h00, 1'b0, 1'b0, 2'd0, 1'b0, 6'h00}, // R1 empty
        '{OP_FILL,  4'd4,  8'h0F, 6'h00, 6'h0D, 1'b0, 1'b0, 2'd0, 1'b0, 6'h00},
        '{OP_LOOK,  4'd3,  8'h0F, 6'h14, 6'h00, 1'b0, 1'b0, 2'd0, 1'b1, 6'h0D}, // R3 R4
        '{OP_FILL,  4'd5,  8'h03, 6'h00, 6'h02, 1'b0, 1'b0, 2'd0, 1'b0, 6'h00},
        '{OP_FILL,  4'd5,  8'h07, 6'h00, 6'h22, 1'b0, 1'b0, 2'd0, 1'b0, 6'h00},
        '{OP_FILL,  4'd5,  8'h0B, 6'h00, 6'h11, 1'b1, 1'b0, 2'd0, 1'b0, 6'h00},
        '{OP_LOOK,  4'd5,  8'h03, 6'h01, 6'h00, 1'b0, 1'b0, 2'd0, 1'b1, 6'h02}, // R5
        '{OP_LOOK,  4'd5,  8'h07, 6'h3F, 6'h00, 1'b0, 1'b0, 2'd0, 1'b1, 6'h22},
        '{OP_LOOK,  4'd5,  8'h0B, 6'h00, 6'h00, 1'b0, 1'b0, 2'd0, 1'b1, 6'h11},
        '{OP_FILL,  4'd7,  8'h0F, 6'h00, 6'h2A, 1'b0, 1'b0, 2'd0, 1'b0, 6'h00},
        '{OP_LOOK,  4'd7,  8'h0F, 6'h20, 6'h00, 1'b0, 1'b0, 2'd0, 1'b1, 6'h2A}, // R7
        '{OP_LOOK,  4'd7,  8'h03, 6'h02, 6'h00, 1'b0, 1'b0, 2'd0, 1'b1, 6'h02},
        '{OP_FILL,  4'd6,  8'h13, 6'h00, 6'h05, 1'b0, 1'b0, 2'd0, 1'b0, 6'h00},
        '{OP_LOOK,  4'd6,  8'h03, 6'h02, 6'h00, 1'b0, 1'b0, 2'd0, 1'b0, 6'h00}, // R6 way1
        '{OP_LOOK,  4'd6,  8'h13, 6'h05, 6'h00, 1'b0, 1'b0, 2'd0, 1'b1, 6'h05},
        '{OP_LOOK,  4'd6,  8'h0F, 6'h00, 6'h00, 1'b0, 1'b0, 2'd0, 1'b1, 6'h2A},
        '{OP_FILL,  4'd6,  8'h17, 6'h00, 6'h06, 1'b0, 1'b0, 2'd0, 1'b0, 6'h00},
        '{OP_LOOK,  4'd6,  8'h07, 6'h00, 6'h00, 1'b0, 1'b0, 2'd0, 1'b0, 6'h00}, // R6 way2
        '{OP_LOOK,  4'd6,  8'h17, 6'h09, 6'h00, 1'b0, 1'b0, 2'd0, 1'b1, 6'h06},
        '{OP_FILL,  4'd2,  8'h00, 6'h00, 6'h28, 1'b0, 1'b0, 2'd0, 1'b0, 6'h00},
        '{OP_LOOK,  4'd2,  8'h00, 6'h2C, 6'h00, 1'b0, 1'b0, 2'd0, 1'b1, 6'h28}, // R2
        '{OP_LOOK,  4'd2,  8'h04, 6'h00, 6'h00, 1'b0, 1'b0, 2'd0, 1'b0, 6'h00},
        '{OP_LOOK,  4'd2,  8'h01, 6'h00, 6'h00, 1'b0, 1'b0, 2'd0, 1'b0, 6'h00},
        '{OP_FILL,  4'd8,  8'h04, 6'h00, 6'h30, 1'b0, 1'b1, 2'd2, 1'b0, 6'h00},
        '{OP_LOOK,  4'd8,  8'h04, 6'h07, 6'h00, 1'b0, 1'b0, 2'd0, 1'b1, 6'h30}, // R8
        '{OP_FILL,  4'd8,  8'h00, 6'h00, 6'h31, 1'b0, 1'b1, 2'd3, 1'b0, 6'h00},
        '{OP_LOOK,  4'd8,  8'h00, 6'h00, 6'h00, 1'b0, 1'b0, 2'd0, 1'b1, 6'h31},
        '{OP_FILL,  4'd5,  8'h08, 6'h00, 6'h12, 1'b0, 1'b0, 2'd0, 1'b0, 6'h00},
        '{OP_FILL,  4'd5,  8'h0C, 6'h00, 6'h13, 1'b0, 1'b0, 2'd0, 1'b0, 6'h00},
        '{OP_FILL,  4'd6,  8'h10, 6'h00, 6'h14, 1'b0, 1'b0, 2'd0, 1'b0, 6'h00},
        '{OP_LOOK,  4'd6,  8'h0C, 6'h00, 6'h00, 1'b0, 1'b0, 2'd0, 1'b0, 6'h00}, // R6 set0
        '{OP_LOOK,  4'd6,  8'h10, 6'h11, 6'h00, 1'b0, 1'b0, 2'd0, 1'b1, 6'h14},
        '{OP_LOOK,  4'd8,  8'h08, 6'h00, 6'h00, 1'b0, 1'b0, 2'd0, 1'b1, 6'h12}, // R8 vacated way reused
        '{OP_LOOK,  4'd8,  8'h04, 6'h00, 6'h00, 1'b0, 1'b0, 2'd0, 1'b1, 6'h30},
        '{OP_LOOK,  4'd8,  8'h00, 6'h01, 6'h00, 1'b0, 1'b0, 2'd0, 1'b1, 6'h31},
        '{OP_FLUSH, 4'd9,  8'h00, 6'h00, 6'h00, 1'b0, 1'b0, 2'd0, 1'b0, 6'h00},
        '{OP_LOOK,  4'd9,  8'h0B, 6'h15, 6'h00, 1'b0, 1'b0, 2'd0, 1'b1, 6'h11}, // R9
        '{OP_LOOK,  4'd9,  8'h0F, 6'h00, 6'h00, 1'b0, 1'b0, 2'd0, 1'b0, 6'h00},
        '{OP_LOOK,  4'd9,  8'h00, 6'h00, 6'h00, 1'b0, 1'b0, 2'd0, 1'b0, 6'h00},
        '{OP_LOOK,  4'd9,  8'h17, 6'h00, 6'h00, 1'b0, 1'b0, 2'd0, 1'b0, 6'h00},
        '{OP_BOTH,  4'd10, 8'h21, 6'h00, 6'h07, 1'b0, 1'b0, 2'd0, 1'b0, 6'h00},
        '{OP_LOOK,  4'd10, 8'h21, 6'h3E, 6'h00, 1'b0, 1'b0, 2'd0, 1'b1, 6'h07}, // R10
        '{OP_LOOK,  4'd10, 8'h0B, 6'h00, 6'h00, 1'b0, 1'b0, 2'd0, 1'b1, 6'h11}
    };

    task automatic look(input logic [7:0] vpn, input logic [5:0] off,
                        input logic ehit, input logic [5:0] eppn, input int req);
        logic [18:0] act, exp;
        @(negedge clk);
        lk_vaddr_i = {vpn, off};
        #1;
        act = {lk_hit_o, lk_ppn_o, lk_paddr_o};
        exp = ehit ? {1'b1, eppn, eppn, off} : 19'd0;
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d vpn=%h act=%h exp=%h", req, vpn, act, exp);
        end
    endtask

    task automatic fill(input logic [7:0] vpn, input logic [5:0] ppn, input logic glob,
                        input logic steer, input logic [1:0] way, input logic flush);
        @(negedge clk);
        fill_en_i = 1'b1; fill_vpn_i = vpn; fill_ppn_i = ppn;
        fill_glob_i = glob; fill_steer_i = steer; fill_way_i = way; flush_i = flush;
        @(negedge clk);
        fill_en_i = 1'b0; fill_steer_i = 1'b0; flush_i = 1'b0; fill_glob_i = 1'b0;
    endtask

    task automatic flush();
        @(negedge clk);
        flush_i = 1'b1;
        @(negedge clk);
        flush_i = 1'b0;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            unique case (TBL[i].op)
                OP_LOOK:  look(TBL[i].vpn, TBL[i].off, TBL[i].ehit, TBL[i].eppn, int'(TBL[i].req));
                OP_FILL:  fill(TBL[i].vpn, TBL[i].ppn, TBL[i].glob, TBL[i].steer, TBL[i].way, 1'b0);
                OP_FLUSH: flush();
                OP_BOTH:  fill(TBL[i].vpn, TBL[i].ppn, TBL[i].glob, TBL[i].steer, TBL[i].way, 1'b1);
                default:  ;
            endcase
        end

        // R1: reset clears even the global entry
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
        look(8'h0B, 6'h00, 1'b0, 6'h00, 1);

        // R11: the set-3 pointer was at way 3 before reset, so after reset
        // four fills leave it at way 0 and the fifth fill evicts page 0x03.
        fill(8'h03, 6'h01, 1'b0, 1'b0, 2'd0, 1'b0);
        fill(8'h07, 6'h02, 1'b0, 1'b0, 2'd0, 1'b0);
        fill(8'h0B, 6'h03, 1'b0, 1'b0, 2'd0, 1'b0);
        fill(8'h0F, 6'h04, 1'b0, 1'b0, 2'd0, 1'b0);
        fill(8'h13, 6'h05, 1'b0, 1'b0, 2'd0, 1'b0);
        look(8'h03, 6'h00, 1'b0, 6'h00, 11); // R11 evicted
        look(8'h0F, 6'h00, 1'b1, 6'h04, 11); // R11 way3 kept
        look(8'h07, 6'h00, 1'b1, 6'h02, 11);
        look(8'h13, 6'h00, 1'b1, 6'h05, 11);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule